// File: doc/BRIEF.md
# Range-Selectable PWM Timer

An 8-bit up-counting timer that advances on ticks from an internal prescaler or from an external strobe. Outside PWM mode it counts through 0xFF to 0x00, raises an overflow flag and can restart from a reload value. It can also toggle a buzzer line once per overflow. In PWM mode the counting range shrinks to 256, 64, 32 or 16 counts, and the reload register sets the duty of a pulse train on the same pin.

Software drives the block over a small register bus with four addresses. Register writes take effect on the clock edge that samples them. Reads are combinational. The overflow flag drives the interrupt request directly.

Top module: `tmr_pwm_unit`

## Requirements
- R1: After reset, every readable register reads 0x00, `pin_out` is low and `irq` is low.
- R2: With run set (control bit 7) and internal source selected (control bit 3 = 0), the counter advances once every 2^(rate+1) clock cycles. Rate is control bits 6:4. The first advance comes 2^(rate+1) edges after the edge that sets run.
- R3: With control bit 3 = 1, the counter advances exactly once per cycle in which `ext_tick` is high, and never otherwise.
- R4: While run is clear, the counter holds its value whatever `ext_tick` does.
- R5: Outside PWM mode (control bit 0 = 0), an advance from 0xFF gives 0x00 and sets the overflow flag (status bit 0 at address 3), which drives `irq`.
- R6: Outside PWM mode with reload enable set (control bit 2), an advance from 0xFF loads the reload register (address 2) instead of 0x00.
- R7: With buzzer enable set (control bit 1) and PWM off, `pin_out` toggles on every overflow. With neither PWM nor buzzer enabled, `pin_out` is low.
- R8: In PWM mode, control bits {2,1} select the range: 00 gives 256, 01 gives 64, 10 gives 32 and 11 gives 16 counts. Only that many low bits of the counter and reload value are used. The counter returns to 0 and sets the overflow flag once per period.
- R9: In PWM mode, `pin_out` goes high when the counter wraps to 0 and low when the counter reaches the reload value. Each period therefore has reload-value counts high, and a reload of 0 keeps the pin low.
- R10: A write to the counter in PWM mode changes the current period at once: writing one below the reload value makes the next advance drive the pin low.
- R11: A new reload value below the current count produces no low phase in the current period. It applies from the next period.
- R12: The reload register is write-only and reads as 0x00. Writing address 3 loads status bit 0, so software can clear or set the flag. An overflow in the same cycle wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 counter, 2 reload, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_tick | input | 1 | External count strobe, one advance per high cycle |
| pin_out | output | 1 | PWM or buzzer output |
| irq | output | 1 | Overflow interrupt request (status flag) |

## Verification
On every cycle, the embedded assertions check several local rules: internal ticks never come back to back, the counter holds when nothing advances or writes it, and every wrap sets the flag. They also check the reload on a non-PWM overflow, the buzzer toggle, and the PWM level after a wrap for zero and nonzero reload. Other properties span many cycles or depend on register programming, and only the bench scenarios can show them. These are:
- the prescaler period for each rate;
- the full high/low pattern of each range with several reload values;
- the mid-period counter and reload writes;
- the read-back of the write-only register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DW     = 8;
    localparam int PW     = 8;
    localparam int RATE_W = 3;

    typedef enum logic [1:0] {
        A_CTRL   = 2'd0,
        A_COUNT  = 2'd1,
        A_RELOAD = 2'd2,
        A_STATUS = 2'd3
    } addr_e;

    typedef struct packed {
        logic              run;
        logic [RATE_W-1:0] rate;
        logic              ext_sel;
        logic              rld_en;
        logic              buz_en;
        logic              pwm_en;
    } ctrl_t;

    // low-bit mask of the PWM counting range for a 2-bit range code
    function automatic logic [DW-1:0] range_mask(input logic [1:0] code);
        logic [2:0] sh;
        sh = (code == 2'd0) ? 3'd0 : (3'(code) + 3'd1);
        return {DW{1'b1}} >> sh;
    endfunction

    // prescaler bits that must all be one to emit a tick
    function automatic logic [PW-1:0] prescale_mask(input logic [RATE_W-1:0] rate);
        logic [PW-1:0] m;
        for (int i = 0; i < PW; i++) begin
            m[i] = (i <= int'(rate));
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int P_W = PW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              ext_sel,
    input  logic              ext_tick,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    logic [P_W-1:0] div_q;
    logic [P_W-1:0] sel_mask;
    logic           int_tick;

    always_ff @(posedge clk) begin
        if (rst || !run || ext_sel) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + P_W'(1);
        end
    end

    always_comb begin
        sel_mask = P_W'(prescale_mask(rate));
        int_tick = run && !ext_sel && ((div_q | ~sel_mask) == {P_W{1'b1}});
        tick     = ext_sel ? (run && ext_tick) : int_tick;
    end

    // R2: the shortest internal period is two cycles
    p_tick_spaced_r2: assert property (@(posedge clk) disable iff (rst)
        int_tick |=> !int_tick);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int C_W = DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           pwm_en,
    input  logic           rld_en,
    input  logic           buz_en,
    input  logic [C_W-1:0] rld,
    input  logic           cnt_wr,
    input  logic [C_W-1:0] cnt_wdata,
    input  logic           flag_wr,
    input  logic           flag_wdata,
    output logic [C_W-1:0] cnt,
    output logic           flag,
    output logic           pwm_lvl,
    output logic           buz_lvl
);

    logic [C_W-1:0] mask;
    logic [C_W-1:0] rld_low;
    logic [C_W-1:0] nxt;
    logic           wrap;
    logic           match;

    always_comb begin
        mask    = pwm_en ? C_W'(range_mask({rld_en, buz_en})) : {C_W{1'b1}};
        rld_low = rld & mask;
        wrap    = ((cnt & mask) == mask);
        if (wrap) begin
            nxt = (!pwm_en && rld_en) ? rld : '0;
        end else begin
            nxt = cnt + C_W'(1);
        end
        match = pwm_en && ((nxt & mask) == rld_low);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            flag    <= 1'b0;
            pwm_lvl <= 1'b1;
            buz_lvl <= 1'b0;
        end else begin
            if (cnt_wr) begin
                cnt <= cnt_wdata;
            end else if (tick) begin
                cnt <= nxt;
            end

            if (tick && wrap) begin
                flag <= 1'b1;
            end else if (flag_wr) begin
                flag <= flag_wdata;
            end

            if (tick && pwm_en) begin
                if (match) begin
                    pwm_lvl <= 1'b0;
                end else if (wrap) begin
                    pwm_lvl <= 1'b1;
                end
            end

            if (tick && wrap && !pwm_en && buz_en) begin
                buz_lvl <= !buz_lvl;
            end
        end
    end

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt));

    p_flag_on_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && wrap) |=> flag);

    p_reload_on_ovf_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && wrap && !pwm_en && rld_en && !cnt_wr) |=> (cnt == $past(rld)));

    p_buz_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && wrap && !pwm_en && buz_en) |=> (buz_lvl != $past(buz_lvl)));

    p_wrap_high_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && wrap && pwm_en && (rld_low != '0)) |=> pwm_lvl);

    p_zero_duty_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && wrap && pwm_en && (rld_low == '0)) |=> !pwm_lvl);

endmodule

// File: rtl/tmr_pwm_unit.sv
module tmr_pwm_unit
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ext_tick,
    output logic          pin_out,
    output logic          irq
);

    ctrl_t         ctrl_q;
    logic [DW-1:0] rld_q;
    logic [DW-1:0] cnt;
    logic          flag;
    logic          pwm_lvl;
    logic          buz_lvl;
    logic          tick;
    addr_e         addr;

    assign addr = addr_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rld_q  <= '0;
        end else if (bus_wr) begin
            if (addr == A_CTRL) begin
                ctrl_q <= ctrl_t'(bus_wdata);
            end
            if (addr == A_RELOAD) begin
                rld_q <= bus_wdata;
            end
        end
    end

    tmr_prescaler #(.P_W(PW)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.run),
        .ext_sel  (ctrl_q.ext_sel),
        .ext_tick (ext_tick),
        .rate     (ctrl_q.rate),
        .tick     (tick)
    );

    tmr_counter #(.C_W(DW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .pwm_en     (ctrl_q.pwm_en),
        .rld_en     (ctrl_q.rld_en),
        .buz_en     (ctrl_q.buz_en),
        .rld        (rld_q),
        .cnt_wr     (bus_wr && (addr == A_COUNT)),
        .cnt_wdata  (bus_wdata),
        .flag_wr    (bus_wr && (addr == A_STATUS)),
        .flag_wdata (bus_wdata[0]),
        .cnt        (cnt),
        .flag       (flag),
        .pwm_lvl    (pwm_lvl),
        .buz_lvl    (buz_lvl)
    );

    always_comb begin
        unique case (addr)
            A_CTRL:   bus_rdata = DW'(ctrl_q);
            A_COUNT:  bus_rdata = cnt;
            A_RELOAD: bus_rdata = '0;
            default:  bus_rdata = {{(DW-1){1'b0}}, flag};
        endcase
        if (ctrl_q.pwm_en) begin
            pin_out = pwm_lvl;
        end else begin
            pin_out = ctrl_q.buz_en && buz_lvl;
        end
        irq = flag;
    end

endmodule

// File: tb/tb_tmr_pwm_unit.sv
`timescale 1ns/1ps
module tb_tmr_pwm_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_tick = 1'b0;
    logic       pin_out;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tmr_pwm_unit dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_tick  (ext_tick),
        .pin_out   (pin_out),
        .irq       (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #0.5;
        v = int'(bus_rdata);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            ext_tick = 1'b1;
            @(negedge clk);
            ext_tick = 1'b0;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register", v, 0);
        end
        chk("R1 pin", int'(pin_out), 0);
        chk("R1 irq", int'(irq), 0);

        // R2: prescaler period for every rate
        for (int r = 0; r < 8; r++) begin
            wr(2'd0, 8'h00);
            wr(2'd1, 8'h00);
            wr(2'd0, 8'h80 | 8'(r << 4));
            repeat (3 << (r + 1)) @(posedge clk);
            @(negedge clk);
            rd(2'd1, v);
            chk("R2 count after three periods", v, 3);
        end

        // R4: stopped counter ignores strobes
        wr(2'd0, 8'h08);
        wr(2'd1, 8'd5);
        step(3);
        rd(2'd1, v);
        chk("R4 hold while stopped", v, 5);

        // R3: external strobes only
        wr(2'd0, 8'h88);
        step(3);
        rd(2'd1, v);
        chk("R3 three strobes", v, 8);
        repeat (20) @(negedge clk);
        rd(2'd1, v);
        chk("R3 no strobe no advance", v, 8);

        // R5: plain overflow
        wr(2'd3, 8'h00);
        wr(2'd1, 8'hFE);
        step(1);
        rd(2'd1, v);
        chk("R5 count before wrap", v, 255);
        chk("R5 no flag yet", int'(irq), 0);
        step(1);
        rd(2'd1, v);
        chk("R5 wraps to zero", v, 0);
        chk("R5 flag on overflow", int'(irq), 1);

        // R12: status write, write-only reload
        wr(2'd3, 8'h00);
        chk("R12 flag cleared", int'(irq), 0);
        wr(2'd3, 8'h01);
        chk("R12 flag set by write", int'(irq), 1);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h5A);
        rd(2'd2, v);
        chk("R12 reload reads zero", v, 0);

        // R6: reload on overflow
        wr(2'd2, 8'hA0);
        wr(2'd0, 8'h8C);
        wr(2'd1, 8'hFF);
        step(1);
        rd(2'd1, v);
        chk("R6 reload value", v, 160);

        // R7: buzzer toggling
        wr(2'd0, 8'h8A);
        chk("R7 buzzer starts low", int'(pin_out), 0);
        wr(2'd1, 8'hFF);
        step(1);
        chk("R7 toggled high", int'(pin_out), 1);
        wr(2'd0, 8'h88);
        chk("R7 pin low with no output mode", int'(pin_out), 0);
        wr(2'd0, 8'h8A);
        chk("R7 buzzer level kept", int'(pin_out), 1);
        wr(2'd1, 8'hFF);
        step(1);
        chk("R7 toggled low", int'(pin_out), 0);

        // R8, R9: every range with several duties
        for (int code = 0; code < 4; code++) begin
            int rng;
            int rv[4];
            rng = 256 >> ((code == 0) ? 0 : code + 1);
            rv[0] = 0; rv[1] = 1; rv[2] = rng / 2; rv[3] = rng - 1;
            for (int k = 0; k < 4; k++) begin
                int high_cnt;
                wr(2'd0, 8'h00);
                wr(2'd1, 8'h00);
                wr(2'd2, 8'(rv[k]));
                wr(2'd3, 8'h00);
                wr(2'd0, 8'h89 | 8'(code << 1));
                step(rng);
                chk("R8 flag after one period", int'(irq), 1);
                wr(2'd3, 8'h00);
                high_cnt = 0;
                for (int i = 0; i < rng; i++) begin
                    int c;
                    step(1);
                    c = (i + 1) % rng;
                    chk("R9 pwm level", int'(pin_out), (c < rv[k]) ? 1 : 0);
                    high_cnt += int'(pin_out);
                    if (i == rng - 2) chk("R8 no flag mid period", int'(irq), 0);
                end
                chk("R8 flag once per period", int'(irq), 1);
                chk("R9 high counts equal reload", high_cnt, rv[k]);
                rd(2'd1, v);
                chk("R8 counter back at zero", v, 0);
            end
        end

        // R10: counter write shifts the duty at once
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'd100);
        wr(2'd0, 8'h89);
        step(256);
        step(50);
        chk("R10 high before write", int'(pin_out), 1);
        wr(2'd1, 8'd99);
        step(1);
        chk("R10 low right after count write", int'(pin_out), 0);

        // R11: smaller reload waits for the next period
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'd200);
        wr(2'd0, 8'h89);
        step(256);
        step(120);
        chk("R11 high at 120", int'(pin_out), 1);
        wr(2'd2, 8'd50);
        step(135);
        chk("R11 still high at 255", int'(pin_out), 1);
        step(1);
        chk("R11 high after wrap", int'(pin_out), 1);
        step(49);
        chk("R11 high at 49", int'(pin_out), 1);
        step(1);
        chk("R11 low at new reload", int'(pin_out), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule